// File: doc/BRIEF.md
# Byte-Wide Timing Register Loader

This block fills a file of 16-bit timing registers through an 8-bit port, steered by a load strobe and two control inputs. The control inputs are read when the strobe goes low, and they choose between an address cycle and a data byte cycle. The address or data byte itself is written when the strobe goes high again. The strobe is sampled on the system clock, so each of its phases must last at least one clock.

There are two ways to address the registers. In manual mode, an address cycle comes before the data bytes, and the byte-select input picks the low or the high half of the register. In auto mode, one start address is followed by a continuous stream of data bytes. The bytes alternate low then high, and the address steps by one after each high byte. After the last register the address returns to the loaded start address, not to zero. A start address at or above the last register makes the block write that one address over and over.

The outputs are a one-cycle write strobe for each register, a flag that marks a high-byte write, and the flattened contents of the whole register file. What the registers mean is left to the logic that reads them.

Top module: `timing_reg_loader`

## Requirements
- R1: On reset (rst_ni low) every register reads 0, no strobe is active, the mode is manual and the address is 0. A data cycle issued straight after reset therefore writes register 0.
- R2: A falling edge of load_i only chooses the operation. Nothing is written, and no strobe rises, until the following rising edge of load_i.
- R3: A falling edge with data_phase_i=0 and hi_byte_i=0 starts a manual address cycle. On the rising edge the address is taken from data_i[ADDR_W-1:0] and the upper bits are ignored. In manual mode each data cycle (data_phase_i=1) writes data_i into bits [7:0] of the addressed register when hi_byte_i=0, or into bits [15:8] when hi_byte_i=1. The other half is left unchanged, and the address does not move.
- R4: A falling edge with data_phase_i=0 and hi_byte_i=1 arms auto mode. Its rising edge loads the start address from data_i.
- R5: In auto mode, data cycles ignore hi_byte_i. They write the low byte first and the high byte next, and the address advances by 1 after each high byte. All 19 registers can therefore be programmed with 39 load cycles.
- R6: In auto mode, a high-byte write to address NUM_REGS-1 (18) sends the address back to the loaded start address.
- R7: An auto start address of NUM_REGS-1 (18) or greater never changes. Every high-byte write returns the address to that same value.
- R8: A falling edge with data_phase_i=0 and hi_byte_i=0 leaves auto mode and returns the block to manual mode.
- R9: A data cycle aimed at an address of NUM_REGS (19) or above changes no register, raises no strobe bit and does not raise wr_hi_o.
- R10: Each accepted data byte gives exactly one bit of wr_strobe_o, at the written register's index, for one clock. The register contents change on the same edge. wr_hi_o is 1 together with that bit only for a high-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe: a falling edge chooses the operation, a rising edge performs it |
| data_phase_i | input | 1 | 0 = address cycle, 1 = data cycle |
| hi_byte_i | input | 1 | In an address cycle, 1 arms auto mode and 0 selects manual mode; in a manual data cycle, 1 selects the high byte |
| data_i | input | BYTE_W | Address or data byte |
| wr_strobe_o | output | NUM_REGS | One-hot write pulse, one bit per register |
| wr_hi_o | output | 1 | The current write pulse is a high-byte write |
| regs_o | output | NUM_REGS*2*BYTE_W | Register file contents; register i is at bits [i*16 +: 16] |

## Verification
The bench builds the block with its default parameters: 19 registers, 8-bit bytes and a 5-bit address. With these values a sweep can cover every auto start address from 0 to 20. That sweep reaches the wrap back to each start address, the fixed address at 18, and the writes that are ignored at 19 and 20. Each sweep also runs past one full lap, so the high-byte write at the last register and the return to the start are both checked. The bench also runs a full manual load of all registers, an address byte with its upper bits set, and a switch from auto mode back to manual.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_ADDR = 2'd1,
    OP_LO   = 2'd2,
    OP_HI   = 2'd3
  } ld_op_e;
endpackage

// File: rtl/ldr_edge.sv
module ldr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic fall_o,
  output logic rise_o
);
  logic load_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b1;
    else         load_q <= load_i;
  end

  assign fall_o = load_q & ~load_i;
  assign rise_o = ~load_q & load_i;
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq #(
  parameter int NUM_REGS = 19,
  parameter int ADDR_W   = 5,
  parameter int BYTE_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              data_phase_i,
  input  logic              hi_byte_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              we_lo_o,
  output logic              we_hi_o,
  output logic [ADDR_W-1:0] waddr_o
);
  import ldr_pkg::*;

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

  ld_op_e            op_q;
  logic              auto_q;
  logic              hi_next_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      auto_q    <= 1'b0;
      hi_next_q <= 1'b0;
      addr_q    <= '0;
      start_q   <= '0;
    end else if (fall_i) begin
      if (!data_phase_i) begin
        op_q   <= OP_ADDR;
        auto_q <= hi_byte_i;
      end else if (auto_q) begin
        op_q <= hi_next_q ? OP_HI : OP_LO;
      end else begin
        op_q <= hi_byte_i ? OP_HI : OP_LO;
      end
    end else if (rise_i) begin
      op_q <= OP_IDLE;
      unique case (op_q)
        OP_ADDR: begin
          addr_q    <= data_i[ADDR_W-1:0];
          start_q   <= data_i[ADDR_W-1:0];
          hi_next_q <= 1'b0;
        end
        OP_LO: if (auto_q) hi_next_q <= 1'b1;
        OP_HI: if (auto_q) begin
          hi_next_q <= 1'b0;
          // loop on the loaded start, not on zero
          addr_q    <= (addr_q >= LAST) ? start_q : addr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign we_lo_o = rise_i && (op_q == OP_LO);
  assign we_hi_o = rise_i && (op_q == OP_HI);
  assign waddr_o = addr_q;
endmodule

// File: rtl/ldr_regfile.sv
module ldr_regfile #(
  parameter int NUM_REGS = 19,
  parameter int ADDR_W   = 5,
  parameter int BYTE_W   = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_lo_i,
  input  logic                           we_hi_i,
  input  logic [ADDR_W-1:0]              waddr_i,
  input  logic [BYTE_W-1:0]              wdata_i,
  output logic [NUM_REGS*2*BYTE_W-1:0]   regs_o,
  output logic [NUM_REGS-1:0]            strobe_o,
  output logic                           hi_o
);
  localparam int REG_W = 2 * BYTE_W;

  logic in_range;
  assign in_range = {1'b0, waddr_i} < (ADDR_W + 1)'(NUM_REGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_o <= 1'b0;
    else         hi_o <= we_hi_i && in_range;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic             hit;
    logic [REG_W-1:0] val_q;

    assign hit = (waddr_i == ADDR_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q       <= '0;
        strobe_o[i] <= 1'b0;
      end else begin
        strobe_o[i] <= hit && (we_lo_i || we_hi_i);
        if (hit && we_lo_i) val_q[BYTE_W-1:0]     <= wdata_i;
        if (hit && we_hi_i) val_q[REG_W-1:BYTE_W] <= wdata_i;
      end
    end

    assign regs_o[i*REG_W +: REG_W] = val_q;
  end
endmodule

// File: rtl/timing_reg_loader.sv
module timing_reg_loader #(
  parameter int NUM_REGS = 19,
  parameter int BYTE_W   = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic                         data_phase_i,
  input  logic                         hi_byte_i,
  input  logic [BYTE_W-1:0]            data_i,
  output logic [NUM_REGS-1:0]          wr_strobe_o,
  output logic                         wr_hi_o,
  output logic [NUM_REGS*2*BYTE_W-1:0] regs_o
);
  localparam int ADDR_W = $clog2(NUM_REGS);

  logic              fall, rise;
  logic              we_lo, we_hi;
  logic [ADDR_W-1:0] waddr;

  ldr_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  ldr_seq #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fall_i       (fall),
    .rise_i       (rise),
    .data_phase_i (data_phase_i),
    .hi_byte_i    (hi_byte_i),
    .data_i       (data_i),
    .we_lo_o      (we_lo),
    .we_hi_o      (we_hi),
    .waddr_o      (waddr)
  );

  ldr_regfile #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .BYTE_W   (BYTE_W)
  ) u_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_lo_i  (we_lo),
    .we_hi_i  (we_hi),
    .waddr_i  (waddr),
    .wdata_i  (data_i),
    .regs_o   (regs_o),
    .strobe_o (wr_strobe_o),
    .hi_o     (wr_hi_o)
  );
endmodule

// File: rtl/timing_reg_loader_chk.sv
module timing_reg_loader_chk #(
  parameter int NUM_REGS = 19,
  parameter int BYTE_W   = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         load_i,
  input logic [NUM_REGS-1:0]          wr_strobe_o,
  input logic                         wr_hi_o,
  input logic [NUM_REGS*2*BYTE_W-1:0] regs_o
);
  localparam int REG_W = 2 * BYTE_W;

  assert_onehot_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_strobe_o));

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_strobe_o) |=> !(|wr_strobe_o));

  assert_hi_with_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_o |-> (|wr_strobe_o));

  assert_write_after_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_strobe_o) |-> ($past(load_i) && !$past(load_i, 2)));

  assert_quiet_regs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|wr_strobe_o) |-> $stable(regs_o));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_half
    assert_lo_keeps_hi_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_strobe_o[i] && !wr_hi_o) |->
        $stable(regs_o[i*REG_W+BYTE_W +: BYTE_W]));
  end
endmodule

bind timing_reg_loader timing_reg_loader_chk #(
  .NUM_REGS (NUM_REGS),
  .BYTE_W   (BYTE_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .wr_strobe_o (wr_strobe_o),
  .wr_hi_o     (wr_hi_o),
  .regs_o      (regs_o)
);

// File: tb/timing_reg_loader_tb_top.sv
`timescale 1ns/1ps
module timing_reg_loader_tb_top;
  localparam int NR = 19;
  localparam int BW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            load_i = 1'b1;
  logic            data_phase_i = 1'b0;
  logic            hi_byte_i = 1'b0;
  logic [BW-1:0]   data_i = '0;
  logic [NR-1:0]   wr_strobe_o;
  logic            wr_hi_o;
  logic [NR*16-1:0] regs_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [15:0] exp_r [NR];
  bit          m_auto = 0;
  bit          m_hi   = 0;
  int          m_addr = 0;
  int          m_start = 0;

  always #5 clk_i = ~clk_i;

  timing_reg_loader #(.NUM_REGS(NR), .BYTE_W(BW)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .data_phase_i (data_phase_i),
    .hi_byte_i    (hi_byte_i),
    .data_i       (data_i),
    .wr_strobe_o  (wr_strobe_o),
    .wr_hi_o      (wr_hi_o),
    .regs_o       (regs_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NR; i++)
      check(req, 32'(regs_o[i*16 +: 16]), 32'(exp_r[i]));
  endtask

  // one full load cycle: fall selects, rise performs
  task automatic ld(input bit dp, input bit hb, input logic [7:0] d, input string req);
    logic [NR-1:0] e_strb;
    bit            e_hi;
    bit            hi;
    e_strb = '0;
    e_hi   = 1'b0;
    @(negedge clk_i);
    load_i = 1'b0; data_phase_i = dp; hi_byte_i = hb; data_i = d;
    @(negedge clk_i);
    check("R2 no strobe after fall", 32'(wr_strobe_o), 32'd0);
    load_i = 1'b1;
    @(negedge clk_i);
    if (!dp) begin
      m_auto = hb; m_addr = int'(d[4:0]); m_start = m_addr; m_hi = 0;
    end else begin
      hi = m_auto ? m_hi : hb;
      if (m_addr < NR) begin
        e_strb[m_addr] = 1'b1;
        e_hi = hi;
        if (hi) exp_r[m_addr][15:8] = d;
        else    exp_r[m_addr][7:0]  = d;
      end
      if (m_auto) begin
        if (hi) begin
          m_hi = 0;
          m_addr = (m_addr >= NR - 1) ? m_start : m_addr + 1;
        end else m_hi = 1;
      end
    end
    check(req, 32'(wr_strobe_o), 32'(e_strb));
    check(req, 32'(wr_hi_o), 32'(e_hi));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) exp_r[i] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 strobe at reset", 32'(wr_strobe_o), 32'd0);
    check("R1 hi at reset", 32'(wr_hi_o), 32'd0);
    check_regs("R1 regs at reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    ld(1, 0, 8'h5A, "R1 data after reset hits reg 0");
    check_regs("R1 reg 0 low");

    // R3 manual full load (57 cycles)
    for (int i = 0; i < NR; i++) begin
      ld(0, 0, 8'(i), "R3 manual addr");
      ld(1, 0, 8'(i * 7 + 3), "R3 manual low");
      ld(1, 1, 8'(i * 13 + 1), "R3 manual high");
    end
    check_regs("R3 manual contents");
    ld(0, 0, 8'hE3, "R3 addr upper bits ignored");
    ld(1, 1, 8'h77, "R3 high to reg 3");
    ld(1, 1, 8'h78, "R3 manual no advance");
    check_regs("R3 reg 3 high");

    // R9 out-of-range manual writes
    ld(0, 0, 8'd25, "R9 addr 25");
    ld(1, 0, 8'h99, "R9 ignored low");
    ld(1, 1, 8'h98, "R9 ignored high");
    check_regs("R9 regs unchanged");

    // R4 R5 R6 R7 R9 auto sweep over every start
    for (int s = 0; s <= 20; s++) begin
      int n_hi;
      n_hi = (s < NR) ? 2 * (NR - s) + 1 : 3;
      ld(0, 1, 8'(s), "R4 auto arm");
      for (int k = 0; k < 2 * n_hi; k++)
        ld(1, ~k[1], 8'(s * 17 + k * 5 + 1),
           (s >= NR - 1) ? "R7 fixed start" : "R5 R6 auto stream");
      check_regs("R5 R6 auto contents");
    end

    // R8 back to manual
    ld(0, 1, 8'd2, "R8 arm auto");
    ld(1, 1, 8'h11, "R8 auto low");
    ld(0, 0, 8'd5, "R8 manual addr");
    ld(1, 1, 8'hAA, "R8 manual high");
    ld(1, 1, 8'hAB, "R8 manual high again");
    ld(1, 0, 8'hCC, "R8 manual low");
    check_regs("R8 contents");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule